// File: doc/BRIEF.md
# Bit-Serial Two-Operand Adder

This block adds two small unsigned operands that reach it one bit per clock rather than as parallel words. A start strobe marks the cycle carrying the most significant bit of both operands. The remaining bits follow on the operand lines in the cycles right after it. The block rebuilds each operand by shifting the arriving bits into a register. Once the last bit is in, it forms the sum with the carry kept. In the next cycle it presents the sum together with a one-cycle valid pulse.

A small sequencer steps through idle, bit collection and output. Transactions never overlap. A start strobe seen while one is in flight is dropped. The next transaction may begin in the cycle straight after the valid pulse. The operand width is a parameter and defaults to 2 bits, which gives a 3-bit result.

Top module: `serial_pair_adder`

## Requirements
- R1: While reset is high at a clock edge, the block clears the result to 0 and the valid strobe to 0, and returns to idle.
- R2: The operand bits sampled in the cycle where the start strobe is high while idle are the most significant bits of the two operands.
- R3: The operand bits sampled in the following cycle are the next lower bits, and with the default width of 2 they are the least significant bits.
- R4: The result is the unsigned sum of the two rebuilt operands, one bit wider than an operand, so the carry out is kept (3 + 3 gives 6).
- R5: With the default width, the valid strobe is high for exactly one cycle, two cycles after the start cycle, and the new sum is on the result bus in that same cycle.
- R6: The result bus keeps its value until the next transaction completes, and the valid strobe stays low in between.
- R7: A start strobe in the second-bit cycle or in the valid-pulse cycle is ignored: it produces no extra pulse and does not change the sum.
- R8: A start strobe in the cycle right after the valid pulse begins a new transaction, so back-to-back transactions complete every three cycles.
- R9: While idle and with the start strobe low, the operand lines have no effect on the result or on the valid strobe.
- R10: A reset in the middle of a transaction abandons it, and no valid pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Marks the cycle carrying the first (most significant) operand bits |
| opa_bit_i | input | 1 | Serial bit of operand A |
| opb_bit_i | input | 1 | Serial bit of operand B |
| sum_o | output | OPW+1 (3) | Registered sum of the rebuilt operands |
| sum_vld_o | output | 1 | One-cycle pulse marking a new sum |

## Verification
The hardest case to reach from the ports is a start strobe that falls inside a running transaction. It matters most when it lands in the valid-pulse cycle, because a design with an off-by-one sequencer would accept it there. The stimulus keeps the start strobe high through the second-bit cycle and the pulse cycle. It then starts the next transaction in the very next cycle. A behavioural model, compared every cycle, shows whether those strobes were dropped and whether the following start was taken. Operand pairs where only the most significant bits are set, or only the least significant ones, tell the two bit orders apart.

// File: rtl/serial_pair_adder_pkg.sv
package serial_pair_adder_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_DONE  = 2'd2
  } seq_state_t;

endpackage

// File: rtl/spa_sequencer.sv
module spa_sequencer
  import serial_pair_adder_pkg::*;
#(
  parameter int OPW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic capture_o,
  output logic last_o
);

  localparam int CW = (OPW > 1) ? $clog2(OPW) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(OPW - 1);

  seq_state_t      state_q;
  logic [CW-1:0]   cnt_q;

  assign capture_o = ((state_q == SEQ_IDLE) && start_i) || (state_q == SEQ_SHIFT);
  assign last_o    = capture_o && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            if (last_o) begin
              state_q <= SEQ_DONE;
              cnt_q   <= '0;
            end else begin
              state_q <= SEQ_SHIFT;
              cnt_q   <= cnt_q + 1'b1;
            end
          end
        end
        SEQ_SHIFT: begin
          if (last_o) begin
            state_q <= SEQ_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        SEQ_DONE: begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end
        default: begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  // R5
  last_to_done_chk: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (state_q == SEQ_DONE));

  // R8
  done_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_DONE) |=> (state_q == SEQ_IDLE));

  // R7
  done_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_DONE) |-> !capture_o);

endmodule

// File: rtl/spa_shreg.sv
module spa_shreg #(
  parameter int OPW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           capture_i,
  input  logic           bit_i,
  output logic [OPW-1:0] word_nxt_o
);

  logic [OPW-1:0] sh_q;

  // the newest bit enters at the bottom; the oldest (MSB) ends at the top
  assign word_nxt_o = OPW'({sh_q, bit_i});

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (capture_i) begin
      sh_q <= word_nxt_o;
    end
  end

  // R3
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> (sh_q[0] == $past(bit_i)));

endmodule

// File: rtl/spa_sum_reg.sv
module spa_sum_reg #(
  parameter int OPW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           last_i,
  input  logic [OPW-1:0] opa_i,
  input  logic [OPW-1:0] opb_i,
  output logic [OPW:0]   sum_o,
  output logic           sum_vld_o
);

  localparam int RW = OPW + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o     <= '0;
      sum_vld_o <= 1'b0;
    end else begin
      sum_vld_o <= last_i;
      if (last_i) begin
        sum_o <= RW'(opa_i) + RW'(opb_i);
      end
    end
  end

  // R5
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    sum_vld_o |=> !sum_vld_o);

  // R6
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !last_i |=> $stable(sum_o));

endmodule

// File: rtl/serial_pair_adder.sv
module serial_pair_adder #(
  parameter int OPW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         opa_bit_i,
  input  logic         opb_bit_i,
  output logic [OPW:0] sum_o,
  output logic         sum_vld_o
);

  localparam int NOPS = 2;

  logic                capture;
  logic                last;
  logic [NOPS-1:0]     bits_in;
  logic [OPW-1:0]      words [NOPS];

  assign bits_in = {opb_bit_i, opa_bit_i};

  spa_sequencer #(.OPW(OPW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .capture_o (capture),
    .last_o    (last)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    spa_shreg #(.OPW(OPW)) u_sh (
      .clk        (clk),
      .rst        (rst),
      .capture_i  (capture),
      .bit_i      (bits_in[g]),
      .word_nxt_o (words[g])
    );
  end

  spa_sum_reg #(.OPW(OPW)) u_sum (
    .clk       (clk),
    .rst       (rst),
    .last_i    (last),
    .opa_i     (words[0]),
    .opb_i     (words[1]),
    .sum_o     (sum_o),
    .sum_vld_o (sum_vld_o)
  );

  // R10
  rst_clears_vld_chk: assert property (@(posedge clk)
    rst |=> !sum_vld_o);

endmodule

// File: tb/test_serial_pair_adder.sv
module test_serial_pair_adder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       opa_bit_i = 1'b0;
  logic       opb_bit_i = 1'b0;
  logic [2:0] sum_o;
  logic       sum_vld_o;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    started = 0;
  bit    finished = 0;

  // behavioural model state
  int m_phase = 0;
  int m_a = 0;
  int m_b = 0;
  int m_sum = 0;
  int m_vld = 0;

  always #5 clk = ~clk;

  serial_pair_adder i_serial_pair_adder (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .opa_bit_i (opa_bit_i),
    .opb_bit_i (opb_bit_i),
    .sum_o     (sum_o),
    .sum_vld_o (sum_vld_o)
  );

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_phase = 0; m_a = 0; m_b = 0; m_sum = 0; m_vld = 0;
    end else begin
      m_vld = 0;
      if (m_phase == 0) begin
        if (start_i) begin
          m_a = int'(opa_bit_i); m_b = int'(opb_bit_i); m_phase = 1;
        end
      end else if (m_phase == 1) begin
        m_a = m_a * 2 + int'(opa_bit_i);
        m_b = m_b * 2 + int'(opb_bit_i);
        m_sum = (m_a + m_b) % 8;
        m_vld = 1;
        m_phase = 2;
      end else begin
        m_phase = 0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check({cur_req, " sum"}, int'(sum_o), m_sum);
      check({cur_req, " vld"}, int'(sum_vld_o), m_vld);
    end
  end

  task automatic cyc(input logic s, input logic a, input logic b);
    @(negedge clk);
    start_i = s; opa_bit_i = a; opb_bit_i = b;
  endtask

  // start cycle (MSB), second cycle (LSB), then a cycle where the pulse shows
  task automatic txn(input int x, input int y, input logic noise);
    cyc(1'b1, x[1], y[1]);
    cyc(noise, x[0], y[0]);
    cyc(noise, noise, noise);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check("R1 reset sum", int'(sum_o), 0);
    check("R1 reset vld", int'(sum_vld_o), 0);
    cyc(1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // R2: only MSBs set -> 2 + 2
    cur_req = "R2";
    txn(2, 2, 1'b0);
    check("R2 msb first", int'(sum_o), 4);
    check("R5 pulse", int'(sum_vld_o), 1);
    cyc(1'b0, 1'b0, 1'b0);
    check("R5 single pulse", int'(sum_vld_o), 0);

    // R3: only LSBs set -> 1 + 0
    cur_req = "R3";
    txn(1, 0, 1'b0);
    check("R3 lsb second", int'(sum_o), 1);
    cyc(1'b0, 1'b0, 1'b0);

    // R4: carry kept
    cur_req = "R4";
    txn(3, 3, 1'b0);
    check("R4 carry", int'(sum_o), 6);
    cyc(1'b0, 1'b0, 1'b0);

    // R6 and R9: idle with operand lines toggling
    cur_req = "R9";
    for (int i = 0; i < 8; i++) cyc(1'b0, i[0], i[1]);
    @(negedge clk);
    check("R6 hold sum", int'(sum_o), 6);
    check("R9 idle vld", int'(sum_vld_o), 0);

    // R8: back-to-back over all operand pairs
    cur_req = "R8";
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        txn(a, b, 1'b0);
        check("R4 sum all pairs", int'(sum_o), a + b);
      end

    // R7: start held high through the busy cycles, then back-to-back
    cur_req = "R7";
    txn(1, 2, 1'b1);
    check("R7 sum", int'(sum_o), 3);
    txn(2, 3, 1'b1);
    check("R7 next start taken", int'(sum_o), 5);
    cyc(1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R7 no extra pulse", int'(sum_vld_o), 0);

    // random mix
    cur_req = "R8";
    for (int k = 0; k < 200; k++) begin
      int r = int'($urandom_range(0, 3));
      cyc(r[0], $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    cyc(1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);

    // R10: reset in mid transaction
    cur_req = "R10";
    cyc(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1; start_i = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R10 cleared sum", int'(sum_o), 0);
    repeat (3) begin
      @(negedge clk);
      check("R10 no pulse", int'(sum_vld_o), 0);
    end

    finish_run();
  end

endmodule